// File: doc/BRIEF.md
# Mode-change context save and restore unit

This block holds the state a processor needs to return from a mode change. When an accepted mode change enters a target context, the status word and the re-entry address of the context being left are written into a register pair that belongs to the target context. A return request names the context that is being left. It reads that context's pair back out as a restored status word and a restored program counter, and it raises a one-cycle change-of-flow strobe with them.

There are eight banked pairs. Context codes: 0 supervisor, 1 to 4 interrupt levels 0 to 3, 5 exception, 6 non-maskable interrupt, 7 debug. A debug return is a return request with context 7.

The unit also keeps a cause register. It loads the event's vector offset, truncated to 9 bits and shifted right by two, for the event kinds that are meant to update it. Priority arbitration, instruction decode, re-entry address calculation and vector fetch are all outside this block.

Top module: `ctx_save_unit`

## Requirements
- R1: With `enter_valid` high at a clock edge, `enter_sr` is stored in the status slot selected by `enter_ctx`. No other slot changes.
- R2: With `enter_valid` high at a clock edge, `enter_pc` is stored in the address slot selected by `enter_ctx`. No other slot changes.
- R3: With `ret_valid` high at a clock edge, on the next cycle `cof` is 1 for exactly one cycle. In that cycle `rest_sr` and `rest_pc` carry the pair held for `ret_ctx`.
- R4: Context 7 (debug) has its own pair. Entries into contexts 0 to 6 never alter it, and a return with `ret_ctx`=7 restores from it.
- R5: An accepted event of kind 0 (exception) or kind 1 (interrupt) sets `cause` on the next cycle to bits [8:2] of `enter_offset`. For example, offset 0x50 gives 0x14.
- R6: An accepted event of kind 2 (system call), 3 (breakpoint), 4 (debug stop) or 5 to 7 (reserved) leaves `cause` unchanged.
- R7: Offset bits above bit 8 are ignored, and an interrupt offset updates the cause exactly like an exception offset. Offset 0x250 of kind 1 gives 0x14, the same value as offset 0x50 of kind 0.
- R8: Reset clears every banked pair, `cause`, `rest_sr`, `rest_pc` and `cof` to zero.
- R9: An entry and a return naming the same context in the same cycle give priority to the save. The restored values are the ones being saved in that cycle.
- R10: In a cycle after one without a return request, `cof` is 0 and `rest_sr`/`rest_pc` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_valid | input | 1 | Accepted mode-change request |
| enter_ctx | input | 3 | Target context of the request |
| enter_kind | input | 3 | Event kind (0 exception, 1 interrupt, 2 syscall, 3 breakpoint, 4 debug stop) |
| enter_sr | input | SR_W | Status word of the context being left |
| enter_pc | input | PC_W | Re-entry address of the context being left |
| enter_offset | input | OFS_W | Vector offset of the event |
| ret_valid | input | 1 | Return request |
| ret_ctx | input | 3 | Context being returned from |
| rest_sr | output | SR_W | Restored status word |
| rest_pc | output | PC_W | Restored program counter |
| cof | output | 1 | One-cycle change-of-flow strobe |
| cause | output | 7 | Cause register |

## Verification
A save and a restore can occur in the same cycle. This happens when a new event enters a context while that same context, or another one, is being returned from. The bench drives both requests at one clock edge, once with matching contexts and once with different ones. The scoreboard expects the freshly saved pair in the matching case and the previously held pair in the other case.

// File: rtl/ctx_save_unit.sv
module ctx_save_unit #(
  parameter int SR_W  = 32,
  parameter int PC_W  = 32,
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter_valid,
  input  logic [2:0]       enter_ctx,
  input  logic [2:0]       enter_kind,
  input  logic [SR_W-1:0]  enter_sr,
  input  logic [PC_W-1:0]  enter_pc,
  input  logic [OFS_W-1:0] enter_offset,
  input  logic             ret_valid,
  input  logic [2:0]       ret_ctx,
  output logic [SR_W-1:0]  rest_sr,
  output logic [PC_W-1:0]  rest_pc,
  output logic             cof,
  output logic [6:0]       cause
);
  localparam int NCTX = 8;

  logic [SR_W-1:0] sr_bank [NCTX];
  logic [PC_W-1:0] pc_bank [NCTX];

  wire cause_load = enter_valid && (enter_kind == 3'd0 || enter_kind == 3'd1);
  wire collide    = enter_valid && ret_valid && (enter_ctx == ret_ctx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTX; i++) begin
        sr_bank[i] <= '0;
        pc_bank[i] <= '0;
      end
      rest_sr <= '0;
      rest_pc <= '0;
      cof     <= 1'b0;
      cause   <= '0;
    end else begin
      cof <= ret_valid;
      if (enter_valid) begin
        sr_bank[enter_ctx] <= enter_sr;
        pc_bank[enter_ctx] <= enter_pc;
      end
      if (ret_valid) begin
        rest_sr <= collide ? enter_sr : sr_bank[ret_ctx];
        rest_pc <= collide ? enter_pc : pc_bank[ret_ctx];
      end
      if (cause_load)
        cause <= enter_offset[8:2];
    end
  end
endmodule

module ctx_save_unit_chk #(
  parameter int SR_W  = 32,
  parameter int PC_W  = 32,
  parameter int OFS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enter_valid,
  input logic [2:0]       enter_ctx,
  input logic [2:0]       enter_kind,
  input logic [SR_W-1:0]  enter_sr,
  input logic [PC_W-1:0]  enter_pc,
  input logic [OFS_W-1:0] enter_offset,
  input logic             ret_valid,
  input logic [2:0]       ret_ctx,
  input logic [SR_W-1:0]  rest_sr,
  input logic [PC_W-1:0]  rest_pc,
  input logic             cof,
  input logic [6:0]       cause
);
  assert_cof_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> cof);
  assert_cof_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> (!cof && $stable(rest_pc) && $stable(rest_sr)));
  assert_cause_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_valid && enter_kind <= 3'd1) |=> cause == $past(enter_offset[8:2]));
  assert_cause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_valid && enter_kind <= 3'd1) |=> $stable(cause));
  assert_save_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_valid && ret_valid && enter_ctx == ret_ctx) |=>
      (rest_pc == $past(enter_pc) && rest_sr == $past(enter_sr)));
endmodule

bind ctx_save_unit ctx_save_unit_chk #(.SR_W(SR_W), .PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enter_valid(enter_valid), .enter_ctx(enter_ctx),
  .enter_kind(enter_kind), .enter_sr(enter_sr), .enter_pc(enter_pc),
  .enter_offset(enter_offset), .ret_valid(ret_valid), .ret_ctx(ret_ctx),
  .rest_sr(rest_sr), .rest_pc(rest_pc), .cof(cof), .cause(cause)
);

// File: tb/ctx_save_unit_bench.sv
module ctx_save_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enter_valid = 1'b0;
  logic [2:0]  enter_ctx = '0;
  logic [2:0]  enter_kind = '0;
  logic [31:0] enter_sr = '0;
  logic [31:0] enter_pc = '0;
  logic [15:0] enter_offset = '0;
  logic        ret_valid = 1'b0;
  logic [2:0]  ret_ctx = '0;
  logic [31:0] rest_sr, rest_pc;
  logic        cof;
  logic [6:0]  cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_sr [8];
  logic [31:0] m_pc [8];
  logic [6:0]  m_cause;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  ctx_save_unit u_ctx_save_unit (
    .clk(clk), .rst_n(rst_n), .enter_valid(enter_valid), .enter_ctx(enter_ctx),
    .enter_kind(enter_kind), .enter_sr(enter_sr), .enter_pc(enter_pc),
    .enter_offset(enter_offset), .ret_valid(ret_valid), .ret_ctx(ret_ctx),
    .rest_sr(rest_sr), .rest_pc(rest_pc), .cof(cof), .cause(cause)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cof) begin
      if (exp_q.size() == 0) chk(0, "R3 spurious cof", 64'd1, 64'd0);
      else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rest_pc, rest_sr} == e, t, {rest_pc, rest_sr}, e);
      end
    end
  end

  task automatic drive(bit ev, logic [2:0] ec, logic [2:0] ek, logic [31:0] s,
                       logic [31:0] p, logic [15:0] off, bit rv, logic [2:0] rc, string tag);
    enter_valid = ev; enter_ctx = ec; enter_kind = ek;
    enter_sr = s; enter_pc = p; enter_offset = off;
    ret_valid = rv; ret_ctx = rc;
    if (ev) begin
      m_sr[ec] = s; m_pc[ec] = p;
      if (ek <= 3'd1) m_cause = off[8:2];
    end
    if (rv) begin
      exp_q.push_back({m_pc[rc], m_sr[rc]});
      tag_q.push_back(tag);
    end
    @(posedge clk);
    @(negedge clk);
    enter_valid = 1'b0; ret_valid = 1'b0;
  endtask

  task automatic enter(logic [2:0] c, logic [2:0] k, logic [31:0] s, logic [31:0] p,
                       logic [15:0] off, string tag);
    drive(1, c, k, s, p, off, 0, 0, "");
    chk(cause == m_cause, tag, {57'd0, cause}, {57'd0, m_cause});
  endtask

  task automatic ret(logic [2:0] c, string tag);
    drive(0, 0, 0, 0, 0, 0, 1, c, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_sr[i] = 0; m_pc[i] = 0; end
    m_cause = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(cause == 0 && cof == 0 && rest_pc == 0 && rest_sr == 0, "R8 reset outputs",
        {cause, cof, rest_pc[23:0]}, 64'd0);
    for (int i = 0; i < 8; i++) ret(3'(i), "R8 bank zero after reset");

    for (int i = 0; i < 8; i++)
      enter(3'(i), 3'd0, 32'h1000 + i, 32'h8000_0000 + 32'(i) * 16, 16'(32'h40 + i * 8),
            "R5 cause from exception offset");
    for (int i = 7; i >= 0; i--) ret(3'(i), "R1 R2 R3 restore per context");

    enter(3'd7, 3'd0, 32'hDB00, 32'hDBDB_0000, 16'h50, "R5 offset 0x50");
    chk(cause == 7'h14, "R5 example 0x50", {57'd0, cause}, 64'h14);
    for (int i = 0; i < 7; i++)
      enter(3'(i), 3'd1, 32'h2000 + i, 32'h9000_0000 + i, 16'h100, "R5 interrupt offset");
    ret(3'd7, "R4 debug pair untouched");
    ret(3'd6, "R3 NMI restore");

    enter(3'd5, 3'd0, 32'h5, 32'h55, 16'h1FC, "R5 max offset");
    for (int k = 2; k < 8; k++)
      enter(3'd5, 3'(k), 32'h500 + k, 32'h5500 + k, 16'h0A4, "R6 cause unchanged");
    chk(cause == 7'h7F, "R6 cause held", {57'd0, cause}, 64'h7F);
    ret(3'd5, "R1 latest save wins for kind 7");

    enter(3'd2, 3'd1, 32'h33, 32'h44, 16'h0250, "R7 high bits ignored");
    chk(cause == 7'h14, "R7 0x250 gives 0x14", {57'd0, cause}, 64'h14);

    drive(1, 3'd3, 3'd2, 32'hAAAA, 32'hBBBB, 16'h0, 1, 3'd3, "R9 same context save wins");
    drive(1, 3'd4, 3'd2, 32'hCCCC, 32'hDDDD, 16'h0, 1, 3'd1, "R9 other context old value");
    ret(3'd4, "R2 save in collision cycle");

    begin
      logic [31:0] hp, hs;
      hp = rest_pc; hs = rest_sr;
      repeat (3) @(negedge clk);
      chk(cof == 0, "R10 cof idle", {63'd0, cof}, 64'd0);
      chk(rest_pc == hp && rest_sr == hs, "R10 outputs hold", {rest_pc, rest_sr}, {hp, hs});
    end
    chk(exp_q.size() == 0, "R3 all returns strobed", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R3 actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule